// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block recovers bytes from an asynchronous serial line. The line is first passed through a short synchronizer. Bit timing then moves forward only on a one-clock enable pulse that arrives sixteen times per bit period. A frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. There is no parity bit.

When a frame completes, the recovered byte goes into a single holding register, and a data-present flag tells the host that a byte is waiting. The host collects the byte with a read access on a small select/strobe port. A read drops data-present. Two status flags sit beside the holding register:
- an overrun flag, set when a new byte lands on top of an unread one;
- a frame-error flag, which describes the stop bit of the byte now held.

A dedicated clear strobe wipes all three flags. The baud enable generator, the register file, interrupts and FIFOs live outside this block.

Top module: `serial_byte_rx`

## Requirements
- R1: After reset, dataPresent, overrun and frameErr are all 0.
- R2: A frame (start bit 0, eight data bits LSB first, stop bit 1) results in rdData equal to the sent byte and dataPresent going to 1 one clock after the stop-bit mid sample.
- R3: A read access (selIn=1, strobeIn=1, wrEn=0) clears dataPresent on the next clock edge, unless a new byte completes in that same cycle.
- R4: An access with wrEn=1 has no effect on dataPresent or on the held byte.
- R5: frameErr takes the value of the held byte's stop sample: it is 1 when the stop bit was sampled low, and a later byte with a good stop bit sets it back to 0.
- R6: A byte that completes while dataPresent=1, with no read in that cycle, sets overrun to 1 and replaces the held byte. A read does not clear overrun.
- R7: clearIn=1 sets dataPresent, overrun and frameErr to 0 on the next edge. This takes priority over a byte completing in the same cycle.
- R8: A low pulse on the line that is high again at the eighth enable tick after the falling edge is a false start. It is discarded and produces no byte.
- R9: Bit timing advances only on cycles with tickEn=1. With tickEn held at 0, any line activity leaves dataPresent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | One-clock enable pulse at 16x the bit rate |
| serIn | input | 1 | Asynchronous serial input, idle high |
| selIn | input | 1 | Read port chip select |
| strobeIn | input | 1 | Read port strobe |
| wrEn | input | 1 | 1 = write access, 0 = read access |
| clearIn | input | 1 | Synchronous clear of the receiver status |
| rdData | output | 8 | Byte in the holding register |
| dataPresent | output | 1 | A received byte is waiting to be read |
| overrun | output | 1 | A byte was overwritten before being read |
| frameErr | output | 1 | The held byte had a low stop bit |

## Verification
The checker watches the flag rules on every cycle:
- the flags after reset;
- a read dropping data-present;
- the clear strobe wiping all flags;
- overrun staying set until a clear;
- frame-error following the stop sample of each completed byte;
- data-present never rising in a cycle after one without an enable tick.

Some behaviour shows only in the bench scenarios. These are bit recovery in LSB-first order, false-start rejection, the overwrite of the held byte on overrun, and a write access leaving data-present alone. For each of these the bench compares the recovered bytes and flags against a queue of expected frames.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftEn;   // sample the line into the shift register
    logic byteDone;  // stop bit sampled, move byte to holding register
    logic stopBad;   // stop bit was low (valid with byteDone)
  } rxStrobe_t;

endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tickEn,
  input  logic      lineBit,
  output rxStrobe_t stb
);

  localparam int CNT_W     = $clog2(OVERSAMPLE);
  localparam int BIT_W     = $clog2(DATA_BITS);
  localparam int MID_TICK  = OVERSAMPLE / 2 - 1;
  localparam int LAST_TICK = OVERSAMPLE - 1;

  rxState_t          state;
  logic [CNT_W-1:0]  tickCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              prevSample;

  logic atMid;
  logic atLast;
  logic lastBit;

  assign atMid   = (tickCnt == CNT_W'(MID_TICK));
  assign atLast  = (tickCnt == CNT_W'(LAST_TICK));
  assign lastBit = (bitCnt == BIT_W'(DATA_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      tickCnt    <= '0;
      bitCnt     <= '0;
      prevSample <= 1'b1;
    end else if (tickEn) begin
      prevSample <= lineBit;
      case (state)
        RX_IDLE: begin
          // falling edge seen between two tick samples
          if (prevSample && !lineBit) begin
            state   <= RX_START;
            tickCnt <= '0;
          end
        end
        RX_START: begin
          if (atMid) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            // line high again at mid start bit: false start
            state   <= lineBit ? RX_IDLE : RX_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (atLast) begin
            tickCnt <= '0;
            bitCnt  <= bitCnt + 1'b1;
            if (lastBit) state <= RX_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (atLast) begin
            tickCnt <= '0;
            state   <= RX_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.shiftEn  = tickEn && (state == RX_DATA) && atLast;
    stb.byteDone = tickEn && (state == RX_STOP) && atLast;
    stb.stopBad  = stb.byteDone && !lineBit;
  end

endmodule

// File: rtl/serial_rx_dp.sv
module serial_rx_dp
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 serIn,
  input  rxStrobe_t            stb,
  input  logic                 readAcc,
  input  logic                 clearIn,
  output logic                 lineBit,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 dataPresent,
  output logic                 overrun,
  output logic                 frameErr
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [DATA_BITS-1:0]   shiftReg;
  logic [DATA_BITS-1:0]   holdReg;

  // metastability guard, idle-high reset value
  always_ff @(posedge clk) begin
    if (rst) syncChain <= '1;
    else     syncChain <= {syncChain[SYNC_STAGES-2:0], serIn};
  end
  assign lineBit = syncChain[SYNC_STAGES-1];

  // LSB arrives first: shift in at the top, move right
  always_ff @(posedge clk) begin
    if (rst)              shiftReg <= '0;
    else if (stb.shiftEn) shiftReg <= {lineBit, shiftReg[DATA_BITS-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst)               holdReg <= '0;
    else if (stb.byteDone) holdReg <= shiftReg;
  end
  assign rdData = holdReg;

  always_ff @(posedge clk) begin
    if (rst || clearIn) begin
      dataPresent <= 1'b0;
      overrun     <= 1'b0;
      frameErr    <= 1'b0;
    end else if (stb.byteDone) begin
      dataPresent <= 1'b1;
      frameErr    <= stb.stopBad;
      if (dataPresent && !readAcc) overrun <= 1'b1;
    end else if (readAcc) begin
      dataPresent <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tickEn,
  input  logic                 serIn,
  input  logic                 selIn,
  input  logic                 strobeIn,
  input  logic                 wrEn,
  input  logic                 clearIn,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 dataPresent,
  output logic                 overrun,
  output logic                 frameErr
);

  rxStrobe_t ctrlStb;
  logic      lineBit;
  logic      readAcc;

  assign readAcc = selIn && strobeIn && !wrEn;

  serial_rx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_BITS (DATA_BITS)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .tickEn (tickEn),
    .lineBit(lineBit),
    .stb    (ctrlStb)
  );

  serial_rx_dp #(
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .serIn      (serIn),
    .stb        (ctrlStb),
    .readAcc    (readAcc),
    .clearIn    (clearIn),
    .lineBit    (lineBit),
    .rdData     (rdData),
    .dataPresent(dataPresent),
    .overrun    (overrun),
    .frameErr   (frameErr)
  );

endmodule

// File: rtl/serial_byte_rx_chk.sv
module serial_byte_rx_chk
  import serial_rx_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      tickEn,
  input logic      readAcc,
  input logic      clearIn,
  input rxStrobe_t stb,
  input logic      dataPresent,
  input logic      overrun,
  input logic      frameErr
);

  // R1: flags low in the first cycle out of reset
  a_r1_reset_flags: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (!dataPresent && !overrun && !frameErr));

  // R2: completed byte raises data-present
  a_r2_present_on_done: assert property (@(posedge clk) disable iff (rst)
    (stb.byteDone && !clearIn) |=> dataPresent);

  // R3: read with no completing byte drops data-present
  a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
    (readAcc && !stb.byteDone && !clearIn) |=> !dataPresent);

  // R5: frame-error follows the stop sample of the new byte
  a_r5_frame_follows_stop: assert property (@(posedge clk) disable iff (rst)
    (stb.byteDone && !clearIn) |=> (frameErr == $past(stb.stopBad)));

  // R6: overrun is sticky until clear
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && !clearIn) |=> overrun);

  // R7: clear wipes all flags
  a_r7_clear_wipes: assert property (@(posedge clk) disable iff (rst)
    clearIn |=> (!dataPresent && !overrun && !frameErr));

  // R9: no tick, no new byte
  a_r9_no_tick_no_rise: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> !$rose(dataPresent));

endmodule

bind serial_byte_rx serial_byte_rx_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tickEn     (tickEn),
  .readAcc    (readAcc),
  .clearIn    (clearIn),
  .stb        (ctrlStb),
  .dataPresent(dataPresent),
  .overrun    (overrun),
  .frameErr   (frameErr)
);

// File: tb/serial_byte_rx_bench.sv
module serial_byte_rx_bench;

  localparam int TICK_DIV = 4;              // clocks per enable tick
  localparam int BIT_CLK  = 16 * TICK_DIV;  // clocks per bit

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickEn = 1'b0;
  logic       serIn = 1'b1;
  logic       selIn = 1'b0;
  logic       strobeIn = 1'b0;
  logic       wrEn = 1'b0;
  logic       clearIn = 1'b0;
  logic [7:0] rdData;
  logic       dataPresent;
  logic       overrun;
  logic       frameErr;

  logic       tickGate = 1'b1;
  logic       autoRead = 1'b0;
  int         tickCnt = 0;
  int         checks = 0;
  int         fails = 0;
  bit         finished = 1'b0;
  logic [8:0] expQ[$];
  logic [8:0] expV;

  always #4 clk = ~clk;  // 125 MHz

  serial_byte_rx u_serial_byte_rx (
    .clk(clk), .rst(rst), .tickEn(tickEn), .serIn(serIn),
    .selIn(selIn), .strobeIn(strobeIn), .wrEn(wrEn), .clearIn(clearIn),
    .rdData(rdData), .dataPresent(dataPresent), .overrun(overrun),
    .frameErr(frameErr)
  );

  // enable pulse generator
  initial begin
    forever begin
      @(negedge clk);
      tickCnt = (tickCnt + 1) % TICK_DIV;
      tickEn <= tickGate && (tickCnt == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic busAccess(input bit isWrite);
    wrEn <= isWrite; selIn <= 1'b1; strobeIn <= 1'b1;
    @(negedge clk);
    wrEn <= 1'b0; selIn <= 1'b0; strobeIn <= 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseClear();
    clearIn <= 1'b1;
    @(negedge clk);
    clearIn <= 1'b0;
    @(negedge clk);
  endtask

  // driver: one frame, then one idle bit; pushes expectation when asked
  task automatic sendFrame(input logic [7:0] b, input bit stopHigh, input bit push);
    if (push) expQ.push_back({~stopHigh, b});
    serIn <= 1'b0;
    repeat (BIT_CLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      serIn <= b[i];
      repeat (BIT_CLK) @(negedge clk);
    end
    serIn <= stopHigh;
    repeat (BIT_CLK) @(negedge clk);
    serIn <= 1'b1;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  // monitor: compares each delivered byte with the scoreboard, then reads it
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && autoRead && dataPresent) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2/R8 unexpected byte", int'(rdData), 0);
        end else begin
          expV = expQ.pop_front();
          chk(rdData == expV[7:0], "R2 byte value", int'(rdData), int'(expV[7:0]));
          chk(frameErr == expV[8], "R5 frame flag", int'(frameErr), int'(expV[8]));
        end
        busAccess(1'b1);
        chk(dataPresent == 1'b1, "R4 write leaves dataPresent", int'(dataPresent), 1);
        busAccess(1'b0);
        chk(dataPresent == 1'b0, "R3 read clears dataPresent", int'(dataPresent), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk(dataPresent == 1'b0, "R1 reset dataPresent", int'(dataPresent), 0);
    chk(overrun == 1'b0, "R1 reset overrun", int'(overrun), 0);
    chk(frameErr == 1'b0, "R1 reset frameErr", int'(frameErr), 0);
    repeat (BIT_CLK) @(negedge clk);

    // scoreboard traffic: R2, R3, R4, R5
    autoRead = 1'b1;
    sendFrame(8'hA5, 1'b1, 1'b1);
    sendFrame(8'h3C, 1'b1, 1'b1);
    sendFrame(8'h00, 1'b0, 1'b1);  // R5 bad stop
    sendFrame(8'hFF, 1'b1, 1'b1);  // R5 good stop clears flag
    sendFrame(8'h01, 1'b1, 1'b1);
    sendFrame(8'h80, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    chk(expQ.size() == 0, "R2 all frames delivered", expQ.size(), 0);

    // R8 false start
    serIn <= 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    serIn <= 1'b1;
    repeat (12 * BIT_CLK) @(negedge clk);
    chk(dataPresent == 1'b0, "R8 false start gives no byte", int'(dataPresent), 0);
    sendFrame(8'h81, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    chk(expQ.size() == 0, "R8 frame after false start", expQ.size(), 0);

    // R9 no enable ticks
    tickGate = 1'b0;
    repeat (TICK_DIV + 2) @(negedge clk);
    sendFrame(8'h55, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    chk(dataPresent == 1'b0, "R9 no tick no byte", int'(dataPresent), 0);
    tickGate = 1'b1;
    repeat (12 * BIT_CLK) @(negedge clk);
    chk(dataPresent == 1'b0, "R9 still no byte after ticks resume", int'(dataPresent), 0);

    // R6 overrun, R7 clear
    autoRead = 1'b0;
    sendFrame(8'h12, 1'b1, 1'b0);
    chk(overrun == 1'b0, "R6 no overrun on first byte", int'(overrun), 0);
    sendFrame(8'h34, 1'b1, 1'b0);
    chk(overrun == 1'b1, "R6 overrun set", int'(overrun), 1);
    chk(rdData == 8'h34, "R6 new byte replaces old", int'(rdData), 'h34);
    chk(dataPresent == 1'b1, "R6 dataPresent held", int'(dataPresent), 1);
    busAccess(1'b0);
    chk(dataPresent == 1'b0, "R3 manual read clears", int'(dataPresent), 0);
    chk(overrun == 1'b1, "R6 read keeps overrun", int'(overrun), 1);
    pulseClear();
    chk(overrun == 1'b0, "R7 clear drops overrun", int'(overrun), 0);

    sendFrame(8'h77, 1'b0, 1'b0);
    chk(frameErr == 1'b1, "R5 bad stop flagged", int'(frameErr), 1);
    chk(dataPresent == 1'b1, "R2 byte with bad stop present", int'(dataPresent), 1);
    chk(rdData == 8'h77, "R2 byte with bad stop value", int'(rdData), 'h77);
    pulseClear();
    chk(frameErr == 1'b0, "R7 clear drops frameErr", int'(frameErr), 0);
    chk(dataPresent == 1'b0, "R7 clear drops dataPresent", int'(dataPresent), 0);

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule